// File: doc/BRIEF.md
# Two-Gate Counting Barrier

This block holds a group of N processors at a common synchronisation point. A processor signals that it has reached the barrier by raising its own request line. It keeps that line high until the block gives it a release pulse. No processor is released until every one of the N has been admitted. The barrier then lets them go one at a time, in a departure phase. A new round of admissions starts only after the last processor has left.

Internally there is a shared occupancy count and two gates. The admission gate starts open and the exit gate starts closed. Each admission raises the count and closes the admission gate for one cycle. After that cycle the block either reopens the admission gate, if processors are still missing, or opens the exit gate, if the count has reached N. Each departure lowers the count and closes the exit gate for one cycle. After that cycle the block either reopens the exit gate, if processors remain inside, or reopens the admission gate, if the count is back to zero.

Because there are two separate gates, a processor that leaves early and asks to enter again cannot be counted into the next round while others are still leaving. Requests that arrive together are admitted in fixed priority order, one admission every two cycles.

Top module: `syncBarrier`

## Requirements
- R1: After reset the count is zero and the admission gate is open, so no ack or release pulse appears until a request is made. A request raised while idle is acknowledged on the cycle right after the clock edge that samples it.
- R2: Each admission produces a single-cycle pulse on that processor's `arriveAck` bit. A request kept high after its ack is not counted again before that processor is released.
- R3: When several requests are pending, the lowest index is admitted first. Admissions are spaced exactly two cycles apart, because the admission gate stays closed for the cycle after each one.
- R4: No release pulse appears while fewer than N processors have been admitted in the current round.
- R5: Once the N-th admission happens, the first release pulse appears two cycles after the N-th ack. The releases follow every two cycles, in ascending index order regardless of the order of arrival.
- R6: A request raised during the departure phase, including one from a processor that was just released, is held off. It is acknowledged two cycles after the last release pulse of the round.
- R7: Across all processors, at most one ack or release pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| arriveReq | input | N | Per-processor request; held high from arrival until its release pulse |
| arriveAck | output | N | Per-processor single-cycle pulse: arrival admitted and counted |
| releasePulse | output | N | Per-processor single-cycle pulse: processor may proceed past the barrier |

## Verification
A wrong count or a misplaced gate shows at the ports within one round. If the count is too low, the release pulses start early and R4 is broken right away. If it is too high, the block never releases anyone and the bench watchdog trips. If a gate reopens at the wrong moment, admissions or departures bunch together. That breaks the two-cycle spacing in the very next cycle, or an early re-entry request is acknowledged during the departure phase. A stale arrival mask shows up as a doubled ack, or as a release pulse sent to a processor that never arrived, and the event scoreboard sees it on the pulse itself.

// File: rtl/syncBarrierPkg.sv
package syncBarrierPkg;

  // Four states of the two gates: each gate is either open or briefly held closed
  typedef enum logic [1:0] {
    PH_ADMIT_OPEN = 2'd0,
    PH_ADMIT_HELD = 2'd1,
    PH_LEAVE_OPEN = 2'd2,
    PH_LEAVE_HELD = 2'd3
  } gatePhase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeArrival;
    logic takeDeparture;
  } barStrobe_t;

endpackage

// File: rtl/syncBarrierPick.sv
module syncBarrierPick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         anyReq
);

  // Ripple chain: a bit is granted only when no lower index is requesting
  logic [N:0] seenLower;

  assign seenLower[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : gPick
    assign grant[g]       = req[g] & ~seenLower[g];
    assign seenLower[g+1] = seenLower[g] | req[g];
  end

  assign anyReq = seenLower[N];

endmodule

// File: rtl/syncBarrierData.sv
module syncBarrierData
  import syncBarrierPkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] arriveReq,
  input  barStrobe_t   strobe,
  output logic         pendingAny,
  output logic         insideAny,
  output logic         countFull,
  output logic         countZero,
  output logic [N-1:0] arriveAck,
  output logic [N-1:0] releasePulse
);

  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] FULL_COUNT = CW'(N);
  localparam logic [CW-1:0] ONE_COUNT  = CW'(1);

  logic [CW-1:0] occupancy;
  logic [N-1:0]  insideMask;
  logic [N-1:0]  ackQ;
  logic [N-1:0]  relQ;
  logic [N-1:0]  pendingReq;
  logic [N-1:0]  arrivePick;
  logic [N-1:0]  departPick;

  // A request counts as new only if that processor is not inside the barrier
  // and is not being released in this cycle
  assign pendingReq = arriveReq & ~insideMask & ~relQ;

  syncBarrierPick #(.N(N)) uArrivePick (
    .req    (pendingReq),
    .grant  (arrivePick),
    .anyReq (pendingAny)
  );

  syncBarrierPick #(.N(N)) uDepartPick (
    .req    (insideMask),
    .grant  (departPick),
    .anyReq (insideAny)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occupancy  <= '0;
      insideMask <= '0;
      ackQ       <= '0;
      relQ       <= '0;
    end else begin
      ackQ <= strobe.takeArrival   ? arrivePick : '0;
      relQ <= strobe.takeDeparture ? departPick : '0;
      if (strobe.takeArrival) begin
        insideMask <= insideMask | arrivePick;
        occupancy  <= occupancy + ONE_COUNT;
      end else if (strobe.takeDeparture) begin
        insideMask <= insideMask & ~departPick;
        occupancy  <= occupancy - ONE_COUNT;
      end
    end
  end

  assign countFull    = (occupancy == FULL_COUNT);
  assign countZero    = (occupancy == '0);
  assign arriveAck    = ackQ;
  assign releasePulse = relQ;

endmodule

// File: rtl/syncBarrierCtrl.sv
module syncBarrierCtrl
  import syncBarrierPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pendingAny,
  input  logic       insideAny,
  input  logic       countFull,
  input  logic       countZero,
  output barStrobe_t strobe
);

  gatePhase_e phase;
  gatePhase_e phaseNext;
  logic       admitGate;
  logic       leaveGate;

  assign admitGate = (phase == PH_ADMIT_OPEN);
  assign leaveGate = (phase == PH_LEAVE_OPEN);

  always_comb begin
    strobe.takeArrival   = admitGate & pendingAny;
    strobe.takeDeparture = leaveGate & insideAny;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_ADMIT_OPEN: if (pendingAny) phaseNext = PH_ADMIT_HELD;
      PH_ADMIT_HELD: phaseNext = countFull ? PH_LEAVE_OPEN : PH_ADMIT_OPEN;
      PH_LEAVE_OPEN: if (insideAny) phaseNext = PH_LEAVE_HELD;
      PH_LEAVE_HELD: phaseNext = countZero ? PH_ADMIT_OPEN : PH_LEAVE_OPEN;
      default:       phaseNext = PH_ADMIT_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_ADMIT_OPEN;
    else       phase <= phaseNext;
  end

endmodule

// File: rtl/syncBarrier.sv
module syncBarrier
  import syncBarrierPkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] arriveReq,
  output logic [N-1:0] arriveAck,
  output logic [N-1:0] releasePulse
);

  barStrobe_t strobe;
  logic       pendingAny;
  logic       insideAny;
  logic       countFull;
  logic       countZero;

  syncBarrierCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .pendingAny (pendingAny),
    .insideAny  (insideAny),
    .countFull  (countFull),
    .countZero  (countZero),
    .strobe     (strobe)
  );

  syncBarrierData #(.N(N)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .arriveReq    (arriveReq),
    .strobe       (strobe),
    .pendingAny   (pendingAny),
    .insideAny    (insideAny),
    .countFull    (countFull),
    .countZero    (countZero),
    .arriveAck    (arriveAck),
    .releasePulse (releasePulse)
  );

endmodule

// File: rtl/syncBarrierChecker.sv
module syncBarrierChecker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic [N-1:0] arriveReq,
  input logic [N-1:0] arriveAck,
  input logic [N-1:0] releasePulse
);

  localparam int CW = $clog2(N + 1);

  // Occupancy and phase rebuilt from the port pulses alone
  logic [CW-1:0] seenInside;
  logic          leavingPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenInside   <= '0;
      leavingPhase <= 1'b0;
    end else if (|arriveAck) begin
      seenInside <= seenInside + CW'(1);
      if (seenInside + CW'(1) == CW'(N)) leavingPhase <= 1'b1;
    end else if (|releasePulse) begin
      seenInside <= seenInside - CW'(1);
      if (seenInside == CW'(1)) leavingPhase <= 1'b0;
    end
  end

  assert_single_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arriveAck, releasePulse}));

  assert_admit_spacing_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|arriveAck) |=> !(|arriveAck));

  assert_release_spacing_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|releasePulse) |=> !(|releasePulse));

  assert_no_early_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|releasePulse) |-> leavingPhase);

  assert_no_admit_while_leaving_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|arriveAck) |-> !leavingPhase);

  for (genvar g = 0; g < N; g++) begin : gAckReq
    assert_ack_follows_request_R2: assert property (@(posedge clk) disable iff (!rstN)
      arriveAck[g] |-> $past(arriveReq[g]));
  end

endmodule

bind syncBarrier syncBarrierChecker #(.N(N)) uChecker (
  .clk          (clk),
  .rstN         (rstN),
  .arriveReq    (arriveReq),
  .arriveAck    (arriveAck),
  .releasePulse (releasePulse)
);

// File: tb/syncBarrier_test.sv
module syncBarrier_test;

  localparam int N = 8;

  typedef struct {
    bit isRel;
    int idx;
  } evItem_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqReg = '0;
  logic [N-1:0] arriveAck;
  logic [N-1:0] releasePulse;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int ackTotal = 0;
  int relTotal = 0;
  int ackCyc[N];
  int relCyc[N];
  bit finished = 1'b0;
  evItem_t expQ[$];

  always #5 clk = ~clk;

  syncBarrier #(.N(N)) uut (
    .clk          (clk),
    .rstN         (rstN),
    .arriveReq    (reqReg),
    .arriveAck    (arriveAck),
    .releasePulse (releasePulse)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Scoreboard monitor: compares every pulse against the queue of expected events
  task automatic matchEvent(input bit isRel, input int idx);
    evItem_t e;
    if (expQ.size() == 0) begin
      check(1'b0, isRel ? "R4 unexpected release" : "R2 unexpected ack", idx, -1);
    end else begin
      e = expQ.pop_front();
      check(e.isRel == isRel && e.idx == idx,
            isRel ? "R5 release order" : "R3 ack order",
            idx + (isRel ? 100 : 0), e.idx + (e.isRel ? 100 : 0));
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if ((arriveAck | releasePulse) != '0)
        check($countones({arriveAck, releasePulse}) == 1, "R7 one event per cycle",
              $countones({arriveAck, releasePulse}), 1);
      for (int i = 0; i < N; i++) begin
        if (arriveAck[i]) begin
          matchEvent(1'b0, i);
          ackCyc[i] = cyc;
          ackTotal++;
        end
        if (releasePulse[i]) begin
          matchEvent(1'b1, i);
          relCyc[i] = cyc;
          relTotal++;
          reqReg[i] = 1'b0;
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 5000) begin
      check(1'b0, "watchdog", cyc, 5000);
      finishUp();
    end
  end

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic expectEv(input bit isRel, input int idx);
    evItem_t e;
    e.isRel = isRel;
    e.idx = idx;
    expQ.push_back(e);
  endtask

  task automatic pushReleases();
    for (int i = 0; i < N; i++) expectEv(1'b1, i);
  endtask

  task automatic waitRel(input int target);
    while (relTotal < target) step(1);
  endtask

  int raiseCyc;
  int baseAck;
  int baseRel;

  initial begin
    for (int i = 0; i < N; i++) begin
      ackCyc[i] = 0;
      relCyc[i] = 0;
    end
    step(5);
    rstN = 1'b1;
    step(3);
    // R1: quiet after reset
    check(arriveAck == '0 && releasePulse == '0, "R1 idle after reset",
          int'(arriveAck | releasePulse), 0);

    // Scenario A: all request together
    for (int i = 0; i < N; i++) expectEv(1'b0, i);
    pushReleases();
    raiseCyc = cyc;
    reqReg = '1;
    waitRel(N);
    check(ackCyc[0] == raiseCyc + 1, "R1 first ack latency", ackCyc[0] - raiseCyc, 1);
    for (int i = 0; i + 1 < N; i++)
      check(ackCyc[i+1] - ackCyc[i] == 2, "R3 admit spacing", ackCyc[i+1] - ackCyc[i], 2);
    check(relCyc[0] - ackCyc[N-1] == 2, "R5 first release latency",
          relCyc[0] - ackCyc[N-1], 2);
    for (int i = 0; i + 1 < N; i++)
      check(relCyc[i+1] - relCyc[i] == 2, "R5 release spacing", relCyc[i+1] - relCyc[i], 2);
    step(4);

    // Scenario B: staggered arrivals in descending-ish order, last one held back
    baseAck = ackTotal;
    baseRel = relTotal;
    for (int i = N - 1; i >= 1; i--) begin
      expectEv(1'b0, i);
      reqReg[i] = 1'b1;
      step(3);
    end
    step(20);
    check(relTotal == baseRel, "R4 no release before all arrive", relTotal - baseRel, 0);
    check(ackTotal - baseAck == N - 1, "R2 held request counted once",
          ackTotal - baseAck, N - 1);
    expectEv(1'b0, 0);
    pushReleases();
    reqReg[0] = 1'b1;
    waitRel(baseRel + N);
    check(relCyc[0] - ackCyc[0] == 2, "R5 release after last ack",
          relCyc[0] - ackCyc[0], 2);
    step(4);

    // Scenario C: processor 0 tries to re-enter right after its release
    baseRel = relTotal;
    for (int i = 0; i < N; i++) expectEv(1'b0, i);
    pushReleases();
    expectEv(1'b0, 0);
    reqReg = '1;
    waitRel(baseRel + 1);
    reqReg[0] = 1'b1;
    baseAck = ackTotal;
    waitRel(baseRel + N);
    step(4);
    check(ackTotal - baseAck == 1, "R6 re-entry admitted once", ackTotal - baseAck, 1);
    check(ackCyc[0] - relCyc[N-1] == 2, "R6 re-entry waits for last release",
          ackCyc[0] - relCyc[N-1], 2);
    check(expQ.size() == 0, "R7 scoreboard drained", expQ.size(), 0);
    finishUp();
  end

endmodule